// File: doc/BRIEF.md
# 4B/5B Code Group to MII Receive Bridge

This block sits between the receive side of a serial link and an external Ethernet MAC. Each clock it accepts one 5-bit code group recovered from the link. It turns the stream into MII-style receive signals: a data-valid strobe, a 4-bit nibble and an error flag. The block stays quiet until the link receiver reports frame synchronization.

A packet opens with the two-symbol start delimiter J followed by K. The J symbol is absorbed. The K symbol becomes the first nibble presented to the MAC, with value 0101. Data code groups are decoded to nibbles. A T symbol closes the packet, and the R symbol after it is swallowed. Bad code groups inside a packet are flagged on the error output. If synchronization is lost mid-packet, the packet is cut short with a flagged final nibble.

With the default parameters the outputs are registered, so each nibble appears one clock after its code group is presented. An optional input register stage (`IN_REG`) adds one more clock.

Top module: `mii_rx_bridge`

## Requirements
- R1: While rst_ni is low, and on the first sample after reset, rxdv_o, rxer_o and rxd_o are all zero.
- R2: While sync_i is low, no packet can start: J (11000) followed by K (10001) produces no rxdv_o.
- R3: The J code group (11000) is absorbed. The output for its cycle is rxdv_o=0, rxd_o=0.
- R4: A K (10001) directly after J with sync_i high drives rxdv_o=1, rxd_o=0101, rxer_o=0, one clock after K is presented (IN_REG=0).
- R5: Inside a packet, data code groups decode to nibbles with rxdv_o=1 and rxer_o=0: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R6: T (01101) inside a packet drops rxdv_o in its output cycle. The next code group (normally R, 00111) is consumed with rxdv_o low.
- R7: A K not directly preceded by J is ignored while idle. A J followed by anything other than K or J returns to idle. Repeated J keeps the block waiting for K.
- R8: Any non-data code group other than T inside a packet gives rxdv_o=1, rxer_o=1, rxd_o=0 for that nibble, and the packet continues.
- R9: If sync_i is low during a packet, that cycle's output is rxdv_o=1, rxer_o=1, rxd_o=0. After it, rxdv_o stays low.
- R10: Between packets, idle code groups (11111) give rxdv_o=0, rxer_o=0, rxd_o=0, and rxer_o is never high without rxdv_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Code group clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_i | input | 1 | Frame synchronization reached by the link receiver |
| cg_i | input | 5 | Code group, one per clock |
| rxdv_o | output | 1 | Receive data valid |
| rxd_o | output | 4 | Receive nibble |
| rxer_o | output | 1 | Receive error for the current nibble |

## Verification
The assertions assume the link presents a fresh code group every clock. They also assume sync_i is a level that can change on any clock, not only at packet boundaries. The bench drives inputs on falling edges, with one code group per clock. It includes sync changes both between packets and mid-packet, so every property sees stimulus within these assumptions. The start-of-packet property expects the K nibble to follow a J accepted one clock earlier, which holds for any code group sequence.

// File: rtl/mii_rx_pkg.sv
package mii_rx_pkg;
  localparam int CG_W  = 5;
  localparam int NIB_W = 4;

  localparam logic [CG_W-1:0] CG_I = 5'b11111;
  localparam logic [CG_W-1:0] CG_J = 5'b11000;
  localparam logic [CG_W-1:0] CG_K = 5'b10001;
  localparam logic [CG_W-1:0] CG_T = 5'b01101;
  localparam logic [CG_W-1:0] CG_R = 5'b00111;

  localparam logic [NIB_W-1:0] NIB_SFD = 4'b0101;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_J    = 2'd1,
    ST_PKT  = 2'd2,
    ST_TAIL = 2'd3
  } rx_state_e;

  typedef struct packed {
    logic             dv;
    logic             er;
    logic [NIB_W-1:0] d;
  } mii_nib_t;
endpackage

// File: rtl/mii_rx_decode.sv
module mii_rx_decode
  import mii_rx_pkg::*;
(
  input  logic [CG_W-1:0]  cg_i,
  output logic             is_data_o,
  output logic [NIB_W-1:0] nib_o
);
  always_comb begin
    is_data_o = 1'b1;
    nib_o     = '0;
    unique case (cg_i)
      5'b11110: nib_o = 4'h0;
      5'b01001: nib_o = 4'h1;
      5'b10100: nib_o = 4'h2;
      5'b10101: nib_o = 4'h3;
      5'b01010: nib_o = 4'h4;
      5'b01011: nib_o = 4'h5;
      5'b01110: nib_o = 4'h6;
      5'b01111: nib_o = 4'h7;
      5'b10010: nib_o = 4'h8;
      5'b10011: nib_o = 4'h9;
      5'b10110: nib_o = 4'hA;
      5'b10111: nib_o = 4'hB;
      5'b11010: nib_o = 4'hC;
      5'b11011: nib_o = 4'hD;
      5'b11100: nib_o = 4'hE;
      5'b11101: nib_o = 4'hF;
      default:  is_data_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/mii_rx_delim_fsm.sv
module mii_rx_delim_fsm
  import mii_rx_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CG_W-1:0]  cg_i,
  input  logic             is_data_i,
  input  logic [NIB_W-1:0] nib_i,
  output mii_nib_t         nib_d_o
);
  rx_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    nib_d_o = '0;
    unique case (state_q)
      ST_IDLE: if (sync_i && cg_i == CG_J) state_d = ST_J;
      ST_J: begin
        if (!sync_i)             state_d = ST_IDLE;
        else if (cg_i == CG_K) begin
          state_d   = ST_PKT;
          nib_d_o.dv = 1'b1;
          nib_d_o.d  = NIB_SFD;
        end
        else if (cg_i != CG_J)   state_d = ST_IDLE;
      end
      ST_PKT: begin
        if (!sync_i) begin
          // cut packet short, flag last nibble
          state_d    = ST_IDLE;
          nib_d_o.dv = 1'b1;
          nib_d_o.er = 1'b1;
        end else if (cg_i == CG_T) begin
          state_d = ST_TAIL;
        end else if (is_data_i) begin
          nib_d_o.dv = 1'b1;
          nib_d_o.d  = nib_i;
        end else begin
          nib_d_o.dv = 1'b1;
          nib_d_o.er = 1'b1;
        end
      end
      ST_TAIL: state_d = ST_IDLE; // swallow R
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  // R7: packet state is only entered from the J wait state
  assert_pkt_entry_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q != ST_PKT && state_d == ST_PKT) |-> (state_q == ST_J && cg_i == CG_K));
endmodule

// File: rtl/mii_rx_out_reg.sv
module mii_rx_out_reg
  import mii_rx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  mii_nib_t nib_d_i,
  output mii_nib_t nib_q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) nib_q_o <= '0;
    else         nib_q_o <= nib_d_i;
  end
endmodule

// File: rtl/mii_rx_bridge.sv
module mii_rx_bridge
  import mii_rx_pkg::*;
#(
  parameter bit IN_REG = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_i,
  input  logic [CG_W-1:0]  cg_i,
  output logic             rxdv_o,
  output logic [NIB_W-1:0] rxd_o,
  output logic             rxer_o
);
  logic             sync_q;
  logic [CG_W-1:0]  cg_q;
  logic             is_data;
  logic [NIB_W-1:0] nib;
  mii_nib_t         nib_d, nib_q;

  generate
    if (IN_REG) begin : g_in_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          sync_q <= 1'b0;
          cg_q   <= CG_I;
        end else begin
          sync_q <= sync_i;
          cg_q   <= cg_i;
        end
      end
    end else begin : g_in_thru
      assign sync_q = sync_i;
      assign cg_q   = cg_i;
    end
  endgenerate

  mii_rx_decode u_dec (
    .cg_i      (cg_q),
    .is_data_o (is_data),
    .nib_o     (nib)
  );

  mii_rx_delim_fsm u_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sync_i    (sync_q),
    .cg_i      (cg_q),
    .is_data_i (is_data),
    .nib_i     (nib),
    .nib_d_o   (nib_d)
  );

  mii_rx_out_reg u_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .nib_d_i (nib_d),
    .nib_q_o (nib_q)
  );

  assign rxdv_o = nib_q.dv;
  assign rxd_o  = nib_q.d;
  assign rxer_o = nib_q.er;

  assert_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxdv_o |-> (rxd_o == '0 && !rxer_o));

  assert_er_needs_dv_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rxer_o |-> rxdv_o);

  assert_sfd_start_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rxdv_o) |-> ($past(sync_q) && $past(cg_q) == CG_K && rxd_o == NIB_SFD));

  assert_no_start_wo_sync_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_q && !rxdv_o) |=> !rxdv_o);

  assert_sync_loss_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxdv_o && !rxer_o && !sync_q) |=> (rxdv_o && rxer_o && rxd_o == '0));

  assert_tail_end_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rxdv_o && !rxer_o && sync_q && cg_q == CG_T) |=> !rxdv_o);
endmodule

// File: tb/sim_mii_rx_bridge.sv
module sim_mii_rx_bridge;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_i = 1'b0;
  logic [4:0] cg_i = 5'b11111;
  logic       rxdv_o;
  logic [3:0] rxd_o;
  logic       rxer_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  localparam logic [4:0] C_I = 5'b11111, C_J = 5'b11000, C_K = 5'b10001,
                         C_T = 5'b01101, C_R = 5'b00111, C_H = 5'b00100;

  always #2 clk_i = ~clk_i; // 250 MHz

  mii_rx_bridge u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_i(sync_i), .cg_i(cg_i),
    .rxdv_o(rxdv_o), .rxd_o(rxd_o), .rxer_o(rxer_o)
  );

  function automatic logic [4:0] enc(input logic [3:0] n);
    case (n)
      4'h0: return 5'b11110; 4'h1: return 5'b01001;
      4'h2: return 5'b10100; 4'h3: return 5'b10101;
      4'h4: return 5'b01010; 4'h5: return 5'b01011;
      4'h6: return 5'b01110; 4'h7: return 5'b01111;
      4'h8: return 5'b10010; 4'h9: return 5'b10011;
      4'hA: return 5'b10110; 4'hB: return 5'b10111;
      4'hC: return 5'b11010; 4'hD: return 5'b11011;
      4'hE: return 5'b11100; default: return 5'b11101;
    endcase
  endfunction

  task automatic chk(input string req, input logic dv, input logic [3:0] d, input logic er);
    n_chk++;
    if (rxdv_o !== dv || rxd_o !== d || rxer_o !== er) begin
      n_fail++;
      $display("FAIL %s: got dv=%b d=%h er=%b, exp dv=%b d=%h er=%b",
               req, rxdv_o, rxd_o, rxer_o, dv, d, er);
    end
  endtask

  // drive one code group, sample its output one clock later
  task automatic step(input logic [4:0] cg, input logic s);
    @(negedge clk_i);
    cg_i = cg; sync_i = s;
    @(posedge clk_i); #1;
  endtask

  task automatic t_reset;
    chk("R1 in reset", 1'b0, 4'h0, 1'b0);
    @(negedge clk_i); rst_ni = 1'b1;
    step(C_I, 1'b0);
    chk("R1 after reset", 1'b0, 4'h0, 1'b0);
  endtask

  task automatic t_no_sync;
    step(C_J, 1'b0); chk("R2 J no sync", 1'b0, 4'h0, 1'b0);
    step(C_K, 1'b0); chk("R2 K no sync", 1'b0, 4'h0, 1'b0);
    step(enc(4'h3), 1'b0); chk("R2 data no sync", 1'b0, 4'h0, 1'b0);
  endtask

  task automatic t_packet;
    step(C_I, 1'b1); chk("R10 idle", 1'b0, 4'h0, 1'b0);
    step(C_J, 1'b1); chk("R3 J absorbed", 1'b0, 4'h0, 1'b0);
    step(C_K, 1'b1); chk("R4 K nibble", 1'b1, 4'h5, 1'b0);
    for (int i = 0; i < 16; i++) begin
      step(enc(4'(i)), 1'b1); chk("R5 data", 1'b1, 4'(i), 1'b0);
    end
    step(C_T, 1'b1); chk("R6 T ends", 1'b0, 4'h0, 1'b0);
    step(C_R, 1'b1); chk("R6 R consumed", 1'b0, 4'h0, 1'b0);
    step(C_I, 1'b1); chk("R10 idle after", 1'b0, 4'h0, 1'b0);
  endtask

  task automatic t_lone_k;
    step(C_K, 1'b1); chk("R7 lone K", 1'b0, 4'h0, 1'b0);
    step(enc(4'h9), 1'b1); chk("R7 data after lone K", 1'b0, 4'h0, 1'b0);
    step(C_J, 1'b1); chk("R3 J", 1'b0, 4'h0, 1'b0);
    step(C_I, 1'b1); chk("R7 J then I", 1'b0, 4'h0, 1'b0);
    step(C_K, 1'b1); chk("R7 K after J,I", 1'b0, 4'h0, 1'b0);
    step(C_J, 1'b1); step(C_J, 1'b1); chk("R7 J J", 1'b0, 4'h0, 1'b0);
    step(C_K, 1'b1); chk("R7 J J K start", 1'b1, 4'h5, 1'b0);
    step(C_T, 1'b1); step(C_R, 1'b1); chk("R6 close", 1'b0, 4'h0, 1'b0);
  endtask

  task automatic t_invalid;
    step(C_J, 1'b1); step(C_K, 1'b1); chk("R4 K", 1'b1, 4'h5, 1'b0);
    step(enc(4'hA), 1'b1); chk("R5 A", 1'b1, 4'hA, 1'b0);
    step(5'b00000, 1'b1); chk("R8 invalid", 1'b1, 4'h0, 1'b1);
    step(C_H, 1'b1); chk("R8 H", 1'b1, 4'h0, 1'b1);
    step(C_K, 1'b1); chk("R8 K in pkt", 1'b1, 4'h0, 1'b1);
    step(enc(4'h7), 1'b1); chk("R8 continues", 1'b1, 4'h7, 1'b0);
    step(C_T, 1'b1); chk("R6 T", 1'b0, 4'h0, 1'b0);
    step(C_R, 1'b1); chk("R6 R", 1'b0, 4'h0, 1'b0);
  endtask

  task automatic t_sync_loss;
    step(C_J, 1'b1); step(C_K, 1'b1);
    step(enc(4'h1), 1'b1); chk("R5 1", 1'b1, 4'h1, 1'b0);
    step(enc(4'h2), 1'b0); chk("R9 sync lost", 1'b1, 4'h0, 1'b1);
    step(enc(4'h3), 1'b1); chk("R9 idle after loss", 1'b0, 4'h0, 1'b0);
    step(C_K, 1'b1); chk("R9 no restart on K", 1'b0, 4'h0, 1'b0);
    step(C_J, 1'b1); step(C_K, 1'b0); chk("R2 K while sync low", 1'b0, 4'h0, 1'b0);
    step(C_I, 1'b1); chk("R10 idle", 1'b0, 4'h0, 1'b0);
  endtask

  initial begin
    #1;
    t_reset();
    t_no_sync();
    t_packet();
    t_lone_k();
    t_invalid();
    t_sync_loss();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk_i);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout, exp completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule